// File: doc/BRIEF.md
# Quadrature encoder position counter

This block turns the two phase signals of an incremental encoder into a signed-direction position count for one axis. Both phase inputs arrive asynchronously. Each passes through a flop synchronizer. A decoder then compares the settled two-bit phase state with the state from the previous clock. Every single-phase change is a count step, so one full cycle of the encoder gives four steps. The phase relationship at each change decides whether the step goes up or down.

The count is 12 bits wide by default and wraps silently at both ends. A short glitch on one phase produces one step and then the opposite step, so the count comes back to where it was. A change of both phases within one sample cannot be decoded. It leaves the count alone and raises a one-cycle error strobe.

Every update of the count comes with a one-cycle event pulse, which downstream flag logic can use. Two instances serve an X/Y pair, and each has its own clear input.

Top module: `qdec_axis`

## Requirements
- R1: With phase A leading, each of the four changes in the phase state {A,B} sequence 00→10→11→01→00 adds one to `position`.
- R2: With phase B leading, each of the four changes in the reverse sequence 00→01→11→10→00 subtracts one from `position`.
- R3: Stepping up from 0xFFF gives 0x000.
- R4: Stepping down from 0x000 gives 0xFFF.
- R5: A pulse on one phase while the other phase is steady produces one step each way, and `position` ends at its earlier value.
- R6: A change of both phases in one sample leaves `position` unchanged, gives no `step_pulse`, and raises `seq_error` for exactly one cycle.
- R7: `step_pulse` is high for exactly one cycle for each update of `position`, and it stays low when the phases do not move.
- R8: While `count_clr` is high, `position` is held at 0x000, and both `step_pulse` and `seq_error` stay low. The phase state is still tracked, so after the clear is released the next single-phase change counts from zero.
- R9: While `rst_n` is low, `position` reads 0x000 and both strobes are low. The phase history resets to state 00.
- R10: A phase change that is driven between clock edges shows up on `position` after the third rising clock edge. The delay is two synchronizer stages plus the count register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_clr | input | 1 | Active-high synchronous clear of the count |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| position | output | CNT_W | Current position count |
| step_pulse | output | 1 | One-cycle pulse on each count update |
| seq_error | output | 1 | One-cycle strobe when both phases changed in one sample |

## Verification
The bench targets the following corner cases:
- Wrap in both directions. A design that saturates or sign-extends would stop at 0xFFF or 0x000 instead of wrapping.
- One-phase glitches on A and on B. A decoder that looks at edges of one phase only would leave a net offset after the glitch.
- A simultaneous change of both phases. A design that guesses a direction would show a spurious step with no error strobe.
- Phase motion during a clear. A design that stops tracking the phase state would count a phantom step when the clear drops.
- Latency, measured at the exact edge. A design with one synchronizer stage too many or too few would shift the update by a cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // State is {a,b}. Moving up, A copies ~B or B copies A.
  function automatic step_e classify(input logic [1:0] prv, input logic [1:0] cur);
    logic a_chg;
    logic b_chg;
    a_chg = prv[1] ^ cur[1];
    b_chg = prv[0] ^ cur[0];
    if (!a_chg && !b_chg)     return STEP_NONE;
    else if (a_chg && b_chg)  return STEP_BAD;
    else if (a_chg)           return (cur[1] == ~prv[0]) ? STEP_UP : STEP_DN;
    else                      return (cur[0] ==  prv[1]) ? STEP_UP : STEP_DN;
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_rest
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase,
  output step_e      step
);

  logic [1:0] prev_q;
  logic [1:0] prev_d;

  always_comb begin
    prev_d = phase;
    step   = classify(prev_q, phase);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= prev_d;
  end

  // R6: an undecodable step flips both phases against the held state
  p_bad_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_BAD) |-> ((phase ^ prev_q) == 2'b11));

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  step_e        step,
  output logic [W-1:0] count,
  output logic         evt,
  output logic         err
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         evt_q, evt_d;
  logic         err_q, err_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    evt_d  = 1'b0;
    err_d  = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (step)
        STEP_UP:   begin cnt_d = cnt_q + ONE; cnt_en = 1'b1; evt_d = 1'b1; end
        STEP_DN:   begin cnt_d = cnt_q - ONE; cnt_en = 1'b1; evt_d = 1'b1; end
        STEP_BAD:  err_d = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      evt_q <= evt_d;
      err_q <= err_d;
    end
  end

  assign count = cnt_q;
  assign evt   = evt_q;
  assign err   = err_q;

  // R7: every change of the count outside a clear is flagged
  p_change_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && (count != $past(count))) |-> evt);

  // R3 / R4: an update moves the count by exactly one, modulo 2^W
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (((count - $past(count)) == ONE) || (($past(count) - count) == ONE)));

  // R8: a clear leaves zero and no strobes
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> ((count == '0) && !evt && !err));

  // R6: an error strobe never comes with a count change
  p_err_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(count) && !evt));

endmodule

// File: rtl/qdec_axis.sv
module qdec_axis
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_clr,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [CNT_W-1:0] position,
  output logic             step_pulse,
  output logic             seq_error
);

  logic       rst_n_s;
  logic [1:0] phase_s;
  step_e      step;

  qdec_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_phase_sync (
    .clk(clk), .rst_n(rst_n_s), .d({enc_a, enc_b}), .q(phase_s)
  );

  qdec_decode u_decode (
    .clk(clk), .rst_n(rst_n_s), .phase(phase_s), .step(step)
  );

  qdec_counter #(.W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n_s), .clr(count_clr), .step(step),
    .count(position), .evt(step_pulse), .err(seq_error)
  );

  // R9: reset forces the outputs quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n_s |-> ((position == '0) && !step_pulse && !seq_error));

endmodule

// File: tb/qdec_axis_tb.sv
`timescale 1ns/1ps
module qdec_axis_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        count_clr;
  logic        enc_a, enc_b;
  logic [11:0] position;
  logic        step_pulse, seq_error;

  always #2.5 clk = ~clk;

  qdec_axis u_dut (
    .clk(clk), .rst_n(rst_n), .count_clr(count_clr),
    .enc_a(enc_a), .enc_b(enc_b),
    .position(position), .step_pulse(step_pulse), .seq_error(seq_error)
  );

  int          tests = 0;
  int          fails = 0;
  int          exp_err = 0;
  int          seen_err = 0;
  logic        mon_on = 1'b0;
  logic [11:0] mdl_cnt;
  logic [1:0]  mdl_ab;
  logic        clr_on;
  logic [11:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] nxt_up(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] nxt_dn(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // driver: applies a phase state and queues the expected result
  task automatic drive(input logic [1:0] ab, input string tag);
    @(negedge clk);
    if (!clr_on) begin
      if (ab == nxt_up(mdl_ab)) begin
        mdl_cnt = mdl_cnt + 12'd1; exp_q.push_back(mdl_cnt); tag_q.push_back(tag);
      end else if (ab == nxt_dn(mdl_ab)) begin
        mdl_cnt = mdl_cnt - 12'd1; exp_q.push_back(mdl_cnt); tag_q.push_back(tag);
      end else if (ab != mdl_ab) begin
        exp_err++;
      end
    end
    mdl_ab = ab;
    {enc_a, enc_b} = ab;
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops one expected value per count update
  always @(negedge clk) begin
    if (mon_on) begin
      if (step_pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected step_pulse", 1, 0);
        end else begin
          logic [11:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(position == e, t, position, e);
        end
      end
      if (seq_error) seen_err++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    {enc_a, enc_b} = 2'b00;
    mdl_ab = 2'b00; mdl_cnt = 12'h000;
    repeat (4) @(negedge clk);
    check(position == 12'h000, "R9 position in reset", position, 0);
    check(!step_pulse && !seq_error, "R9 strobes in reset", {step_pulse, seq_error}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;
    check(position == 12'h000, "R9 position after reset", position, 0);
  endtask

  initial begin
    #1000000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; count_clr = 1'b0; clr_on = 1'b0;
    enc_a = 1'b0; enc_b = 1'b0;
    do_reset();

    // R1: two full forward cycles
    for (int i = 0; i < 8; i++) drive(nxt_up(mdl_ab), "R1 up step");
    check(position == 12'h008, "R1 after 8 up steps", position, 8);

    // R2 and R4: reverse past zero
    for (int i = 0; i < 12; i++) drive(nxt_dn(mdl_ab), "R2/R4 down step");
    check(position == 12'hFFC, "R4 wrap below zero", position, 12'hFFC);

    // R3: forward through 0xFFF
    for (int i = 0; i < 4; i++) drive(nxt_up(mdl_ab), "R3 up across FFF");
    check(position == 12'h000, "R3 wrap above FFF", position, 0);

    // R5: one-phase glitches, state is 00
    drive(2'b10, "R5 A glitch rise");
    drive(2'b00, "R5 A glitch fall");
    check(position == 12'h000, "R5 A glitch net", position, 0);
    drive(2'b01, "R5 B glitch rise");
    drive(2'b00, "R5 B glitch fall");
    check(position == 12'h000, "R5 B glitch net", position, 0);

    // R6: both phases at once, then resume from 11
    drive(2'b11, "R6 illegal");
    check(position == 12'h000, "R6 count unchanged", position, 0);
    drive(2'b01, "R6 resume up");
    drive(2'b00, "R6 resume up");
    check(seen_err == exp_err, "R6 error strobe count", seen_err, exp_err);

    // R7: idle phases give no pulse (the monitor flags any)
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 no pending events", exp_q.size(), 0);

    // R8: clear with phase motion underneath
    @(negedge clk); count_clr = 1'b1; clr_on = 1'b1; mdl_cnt = 12'h000;
    repeat (2) @(negedge clk);
    check(position == 12'h000, "R8 cleared", position, 0);
    drive(2'b10, "R8 step during clear");
    drive(2'b11, "R8 step during clear");
    check(position == 12'h000, "R8 held during clear", position, 0);
    @(negedge clk); count_clr = 1'b0; clr_on = 1'b0;
    drive(2'b01, "R8 first step after clear");
    check(position == 12'h001, "R8 counts from zero", position, 1);

    // R10: latency to the exact edge (state 01 -> 00 is up)
    @(negedge clk);
    mdl_cnt = mdl_cnt + 12'd1; exp_q.push_back(mdl_cnt); tag_q.push_back("R10 step value");
    mdl_ab = 2'b00; {enc_a, enc_b} = 2'b00;
    repeat (2) @(negedge clk);
    check(position == 12'h001, "R10 not before 3rd edge", position, 1);
    @(negedge clk);
    check(position == 12'h002, "R10 at 3rd edge", position, 2);
    repeat (4) @(negedge clk);

    // R3: full forward lap of 4096 steps returns to the start value
    for (int i = 0; i < 4096; i++) drive(nxt_up(mdl_ab), "R3 full lap step");
    check(position == 12'h002, "R3 full lap", position, 2);

    // R9: reset mid-run clears the count
    do_reset();
    drive(nxt_dn(mdl_ab), "R9 first step after reset");
    check(position == 12'hFFF, "R9 counts from zero", position, 12'hFFF);
    check(seen_err == exp_err, "R6 final error count", seen_err, exp_err);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule